// File: doc/BRIEF.md
# Page-Zero Pointer Address Generator

This block produces the effective address for two combined indirect-and-indexed addressing modes of an 8-bit processor with a 16-bit address space. A one-cycle start pulse hands it an operand byte, the two index registers (X and Y) and a mode select. It then reads a two-byte pointer from page zero through a simple synchronous read port and returns the final 16-bit address with a one-cycle done strobe.

In pre-indexed mode X is added to the operand byte first, and the sum, kept to 8 bits, is where the pointer lives. In post-indexed mode the pointer is read from the operand byte as given, and Y is added to the full 16-bit pointer afterwards. A carry into the high byte in that case raises a page-crossing flag. The pointer is stored low byte first, and both pointer byte addresses wrap inside page zero. Reading the data at the final address is left to the surrounding datapath.

Top module: `zpi_agu`

## Requirements
- R1: With mode_pre = 1 the pointer address is (operand + X) mod 256, and ea equals the 16-bit pointer read from there, with no further index added.
- R2: With mode_pre = 0 the pointer address is the operand byte, and ea equals (pointer + Y) mod 65536.
- R3: Every read issued on the memory port has bits 15:8 of mem_addr equal to zero.
- R4: The pointer is little-endian: the low byte is read from the pointer address and the high byte from (pointer address + 1) mod 256, so a pointer at 0xFF takes its high byte from 0x00.
- R5: In pre-indexed mode an operand + X sum above 255 wraps within page zero and never carries into the high address byte.
- R6: page_cross is 1 exactly when, in post-indexed mode, adding Y to the pointer low byte carries into the high byte; it is 0 for every pre-indexed result. It is valid together with ea while done is high.
- R7: After start is sampled high in idle, the block issues exactly two reads (low byte first, one cycle of read latency each) and done rises in the fourth cycle after that edge, high for one cycle only.
- R8: Operand, X, Y and mode are captured on the accepted start edge; start pulses and input changes while busy is high have no effect on the result and cause no further operation.
- R9: After reset busy, done, mem_re, page_cross and ea are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an address computation (ignored while busy) |
| mode_pre | input | 1 | 1 = pre-indexed with X, 0 = post-indexed with Y |
| opnd | input | 8 | Operand byte (page-zero pointer location) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_re | output | 1 | Read request to page-zero memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe, ea and page_cross valid |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Post-index addition crossed into the next page |

## Verification
A wrong pointer location shows up as a wrong ea in the same operation, four cycles after start, and as a read address outside the expected byte on the port one or two cycles after start. A state machine that skips or repeats a state changes the done latency or the read count of that very operation, and a start accepted while busy shows as an extra done or a wrong ea in the next few cycles. Wrap faults only appear with operands or sums near 0xFF, so those are driven directly besides the random mix.

// File: rtl/zpi_pkg.sv
package zpi_pkg;

  localparam int unsigned ZPI_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_CALC = 3'd3,
    ST_DONE = 3'd4
  } zpi_state_e;

  typedef enum logic {
    MODE_POST = 1'b0,
    MODE_PRE  = 1'b1
  } zpi_mode_e;

endpackage

// File: rtl/zpi_ctrl.sv
module zpi_ctrl
  import zpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output zpi_state_e state,
  output logic       accept
);

  zpi_state_e state_d;

  always_comb begin
    state_d = state;
    accept  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LO;
          accept  = 1'b1;
        end
      end
      ST_LO:   state_d = ST_HI;
      ST_HI:   state_d = ST_CALC;
      ST_CALC: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R7
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LO) |=> (state == ST_HI));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_IDLE));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !accept);

endmodule

// File: rtl/zpi_ptr_addr.sv
module zpi_ptr_addr
  import zpi_pkg::*;
#(
  parameter int unsigned BYTE_W = ZPI_BYTE_W
) (
  input  logic              pre,
  input  logic              sel_hi,
  input  logic [BYTE_W-1:0] opnd,
  input  logic [BYTE_W-1:0] idx_x,
  output logic [BYTE_W-1:0] byte_addr
);

  logic [BYTE_W-1:0] base;
  logic [BYTE_W-1:0] step;

  // Pointer location stays inside page zero: sums are truncated to BYTE_W.
  always_comb begin
    base      = pre ? BYTE_W'(opnd + idx_x) : opnd;
    step      = sel_hi ? BYTE_W'(1) : '0;
    byte_addr = BYTE_W'(base + step);
  end

endmodule

// File: rtl/zpi_index_add.sv
module zpi_index_add
  import zpi_pkg::*;
#(
  parameter int unsigned BYTE_W = ZPI_BYTE_W,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              use_idx,
  input  logic [BYTE_W-1:0] ptr_lo,
  input  logic [BYTE_W-1:0] ptr_hi,
  input  logic [BYTE_W-1:0] idx,
  output logic [ADDR_W-1:0] ea,
  output logic              carry
);

  logic [BYTE_W:0]   lo_sum;
  logic [BYTE_W-1:0] hi_sum;
  logic [BYTE_W-1:0] idx_eff;

  always_comb begin
    idx_eff = use_idx ? idx : '0;
    lo_sum  = {1'b0, ptr_lo} + {1'b0, idx_eff};
    carry   = lo_sum[BYTE_W];
    hi_sum  = BYTE_W'(ptr_hi + {{(BYTE_W-1){1'b0}}, carry});
    ea      = {hi_sum, lo_sum[BYTE_W-1:0]};
  end

endmodule

// File: rtl/zpi_agu.sv
module zpi_agu
  import zpi_pkg::*;
#(
  parameter int unsigned BYTE_W = ZPI_BYTE_W,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_pre,
  input  logic [BYTE_W-1:0] opnd,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic              page_cross
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  zpi_state_e state;
  logic       accept;

  zpi_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (start),
    .state  (state),
    .accept (accept)
  );

  // Captured request.
  logic [BYTE_W-1:0] op_q, x_q, y_q;
  zpi_mode_e         mode_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      op_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      mode_q <= MODE_POST;
    end else if (accept) begin
      op_q   <= opnd;
      x_q    <= idx_x;
      y_q    <= idx_y;
      mode_q <= mode_pre ? MODE_PRE : MODE_POST;
    end
  end

  // Pointer byte address.
  logic [BYTE_W-1:0] ptr_byte;
  logic              sel_hi;

  assign sel_hi = (state == ST_HI);

  zpi_ptr_addr #(.BYTE_W(BYTE_W)) u_ptr (
    .pre       (mode_q == MODE_PRE),
    .sel_hi    (sel_hi),
    .opnd      (op_q),
    .idx_x     (x_q),
    .byte_addr (ptr_byte)
  );

  assign mem_re   = (state == ST_LO) || (state == ST_HI);
  assign mem_addr = {{BYTE_W{1'b0}}, ptr_byte};

  // Low pointer byte arrives during ST_HI.
  logic [BYTE_W-1:0] lo_q;
  logic              lo_en;

  assign lo_en = (state == ST_HI);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata;
  end

  // High byte arrives during ST_CALC; final add then.
  logic [ADDR_W-1:0] ea_d;
  logic              carry_d;
  logic              res_en;

  assign res_en = (state == ST_CALC);

  zpi_index_add #(.BYTE_W(BYTE_W)) u_add (
    .use_idx (mode_q == MODE_POST),
    .ptr_lo  (lo_q),
    .ptr_hi  (mem_rdata),
    .idx     (y_q),
    .ea      (ea_d),
    .carry   (carry_d)
  );

  logic [ADDR_W-1:0] ea_q;
  logic              pc_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ea_q <= '0;
      pc_q <= 1'b0;
    end else if (res_en) begin
      ea_q <= ea_d;
      pc_q <= carry_d;
    end
  end

  assign ea         = ea_q;
  assign page_cross = pc_q;
  assign done       = (state == ST_DONE);
  assign busy       = (state != ST_IDLE);

  // R3
  zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_re |-> (mem_addr[ADDR_W-1:BYTE_W] == '0));

  // R4
  hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state == ST_HI) |-> (mem_addr[BYTE_W-1:0] == BYTE_W'($past(mem_addr[BYTE_W-1:0]) + 1'b1)));

  // R6
  pre_no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done && (mode_q == MODE_PRE)) |-> !page_cross);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && !done) |=> ($stable(op_q) && $stable(x_q) && $stable(y_q)));

  // R7
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> $stable(ea));

endmodule

// File: tb/tb_zpi_agu.sv
module tb_zpi_agu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, mode_pre;
  logic [7:0]  opnd, idx_x, idx_y;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, done, page_cross;
  logic [15:0] ea;

  always #(CLK_PERIOD/2) clk = ~clk;

  zpi_agu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_pre(mode_pre),
    .opnd(opnd), .idx_x(idx_x), .idx_y(idx_y),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea), .page_cross(page_cross)
  );

  logic [7:0] zmem [256];
  int reads, bad_hi;
  logic [7:0] rd_addr [2];

  always_ff @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= zmem[mem_addr[7:0]];
      if (reads < 2) rd_addr[reads] <= mem_addr[7:0];
      reads <= reads + 1;
      if (mem_addr[15:8] != 8'h00) bad_hi <= bad_hi + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] model(input bit pre, input logic [7:0] op,
                                        input logic [7:0] x, input logic [7:0] y);
    logic [7:0]  pa;
    logic [15:0] ptr;
    logic [8:0]  lo;
    pa  = pre ? 8'(op + x) : op;
    ptr = {zmem[8'(pa + 8'd1)], zmem[pa]};
    if (pre) return {1'b0, ptr};
    lo = {1'b0, ptr[7:0]} + {1'b0, y};
    return {lo[8], 16'(ptr + {8'h00, y})};
  endfunction

  task automatic run_op(input bit pre, input logic [7:0] op, input logic [7:0] x,
                        input logic [7:0] y, input bit poke);
    logic [16:0] exp;
    logic [7:0]  pa;
    int n;
    exp = model(pre, op, x, y);
    pa  = pre ? 8'(op + x) : op;
    @(negedge clk);
    reads = 0;
    start = 1; mode_pre = pre; opnd = op; idx_x = x; idx_y = y;
    @(negedge clk);
    start = 0;
    opnd = ~op; idx_x = ~x; idx_y = 8'(y + 8'd77); mode_pre = ~pre;  // R8 inputs change after capture
    n = 1;
    while (!done && n < 20) begin
      if (poke && n == 2) start = 1;   // R8 start while busy
      @(negedge clk);
      start = 0;
      n++;
    end
    check(n == 4, "R7 latency", 32'(n), 32'd4);
    check(reads == 2, "R7 read count", 32'(reads), 32'd2);
    check(bad_hi == 0, "R3 high address byte", 32'(bad_hi), 32'd0);
    check(rd_addr[0] == pa, "R1/R2 pointer address", {24'h0, rd_addr[0]}, {24'h0, pa});
    check(rd_addr[1] == 8'(pa + 8'd1), "R4 high byte address", {24'h0, rd_addr[1]}, {24'h0, 8'(pa + 8'd1)});
    check(ea == exp[15:0], pre ? "R1 ea" : "R2 ea", {16'h0, ea}, {16'h0, exp[15:0]});
    check(page_cross == exp[16], "R6 page_cross", {31'h0, page_cross}, {31'h0, exp[16]});
    @(negedge clk);
    check(!done, "R7 done one cycle", {31'h0, done}, 32'd0);
    if (poke) begin
      repeat (5) begin
        @(negedge clk);
        check(!done && !busy, "R8 ignored start", {30'h0, done, busy}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    reads = 0; bad_hi = 0;
    start = 0; mode_pre = 0; opnd = 0; idx_x = 0; idx_y = 0;
    for (int i = 0; i < 256; i++) zmem[i] = 8'($urandom);
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !mem_re, "R9 controls", {29'h0, busy, done, mem_re}, 32'd0);
    check(ea == 16'h0 && !page_cross, "R9 result", {15'h0, page_cross, ea}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R5 pre-indexed sum wraps: 0xF0 + 0x20 -> 0x10
    zmem[8'h10] = 8'h34; zmem[8'h11] = 8'h12;
    run_op(1, 8'hF0, 8'h20, 8'hFF, 0);
    check(ea == 16'h1234, "R5 wrapped pointer", {16'h0, ea}, 32'h1234);
    // R4 pre-indexed pointer at 0xFF, high byte from 0x00
    zmem[8'hFF] = 8'hCD; zmem[8'h00] = 8'hAB;
    run_op(1, 8'hFE, 8'h01, 8'h00, 0);
    check(ea == 16'hABCD, "R4 pre wrap", {16'h0, ea}, 32'hABCD);
    // R4 post-indexed pointer at 0xFF
    run_op(0, 8'hFF, 8'h55, 8'h02, 0);
    check(ea == 16'hABCF, "R4 post wrap", {16'h0, ea}, 32'hABCF);
    // R6 page crossing and carry out of the top byte
    zmem[8'h40] = 8'hF0; zmem[8'h41] = 8'hFF;
    run_op(0, 8'h40, 8'h00, 8'h20, 0);
    check(ea == 16'h0010 && page_cross, "R6 cross", {15'h0, page_cross, ea}, 32'h10010);
    run_op(0, 8'h40, 8'h00, 8'h00, 0);
    check(!page_cross, "R6 no cross", {31'h0, page_cross}, 32'd0);
    run_op(1, 8'h40, 8'h00, 8'hFF, 0);
    check(!page_cross, "R6 pre never crosses", {31'h0, page_cross}, 32'd0);
    // R8 start while busy
    run_op(0, 8'h40, 8'h11, 8'h05, 1);
    run_op(1, 8'h3C, 8'h04, 8'h99, 1);

    for (int k = 0; k < 300; k++) begin
      if (k % 50 == 0) for (int i = 0; i < 256; i++) zmem[i] = 8'($urandom);
      run_op(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), (k % 17) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule